// File: doc/BRIEF.md
# Register-Exchange Survivor Path Memory

This block is the survivor memory of a four-state soft-decision decoder for a rate-1/2 convolutional code with constraint length 3. It keeps one 16-bit path register for every trellis state. Once per stage, the metric unit supplies one decision bit per state and the index of the state with the smallest accumulated metric. Every path register is then rebuilt from a copy of its winning predecessor's register: the copy moves up one place and the newest input bit enters at the bottom. The oldest bit of the best state's path leaves as the decoded output.

The path depth of 16 covers a decision depth of fifteen stages, which is five times the constraint length. The output stays quiet until the registers have filled. A drain mode then releases, oldest first, the bits still held when the input stream ends. A start pulse clears the memory for a new stream.

Top module: `vit_surv_mem`

## Requirements
- R1: After reset, `bit_vld_o` and `bit_o` are 0, every path register is zero and no bits are pending.
- R2: On a decide stage (`step_i`=1, `flush_i`=0, `start_i`=0), the register of state n (state index bit 1 = newest input bit, bit 0 = the input before it) becomes the previous register of predecessor {n[0], dec_i[n]} moved up by one place, with bit 0 set to n[1]. Bit n of `dec_i` is the decision of state n.
- R3: All four registers update on the same edge, each from the values the registers held before that edge.
- R4: On a decide stage that brings the pending count to 16, `bit_o` becomes bit 15 of the best state's newly written register, `bit_vld_o` is 1 in the cycle after that edge, and the pending count stays at 15.
- R5: The first 15 decide stages after reset or start produce no valid output.
- R6: On a drain stage (`step_i`=1, `flush_i`=1), the path registers hold their values and `dec_i` and `best_i` are ignored. If p > 0 bits are pending, the output is bit p-1 of the register of the best state latched at the last decide stage, and p decreases by one.
- R7: A drain stage with no bits pending produces no valid output.
- R8: Between two starts, decide stages followed by enough drain stages produce exactly one valid output per decide stage, in stage order. This also holds when fewer than 16 stages were decided.
- R9: `start_i` clears the registers, the pending count and `bit_o`, and it overrides a `step_i` in the same cycle.
- R10: `bit_vld_o` is a one-cycle pulse that follows only a step edge, and `bit_o` holds its value on cycles with neither step nor start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the memory for a new stream |
| step_i | input | 1 | Stage strobe |
| flush_i | input | 1 | Qualifies a step as a drain stage |
| dec_i | input | 4 | Per-state decision: which predecessor won |
| best_i | input | 2 | Index of the minimum-metric state |
| bit_o | output | 1 | Decoded bit |
| bit_vld_o | output | 1 | Decoded bit valid, one cycle per emission |

## Verification
The hardest case to reach is a drain that starts while the pending count is below the full depth, either because a start cut the stream short or because the last drain stopped part-way. In that case the output comes from a register position that moves with every drain step. The stimulus creates this case on purpose: a start is issued together with a step, then a short run of decide stages follows, then more drain steps than there are pending bits. A long random phase mixes occasional starts with about one drain step in five, so that drains begin at many different fill levels. In both phases the bench model counts the emitted bits against the decided stages.

// File: rtl/vit_sp_pkg.sv
package vit_sp_pkg;

    // Operation applied to the survivor memory in one cycle
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_DECIDE = 2'd2,
        OP_DRAIN  = 2'd3
    } stage_op_e;

endpackage

// File: rtl/vit_sp_bank.sv
module vit_sp_bank
    import vit_sp_pkg::*;
#(
    parameter  int SB = 2,
    parameter  int W  = 16,
    localparam int NS = 1 << SB
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  stage_op_e               op_i,
    input  logic [NS-1:0]           dec_i,
    output logic [NS-1:0][W-1:0]    surv_q_o,
    output logic [NS-1:0]           nxt_msb_o
);

    typedef struct packed {
        logic [NS-1:0][W-1:0] surv;
    } bank_t;

    bank_t st_d, st_q;

    logic [SB-1:0] pred_idx [NS];
    logic [NS-1:0] ins_bit;

    // Predecessor of state g is {g[SB-2:0], decision}; the bit entering is g's top bit
    generate
        for (genvar g = 0; g < NS; g++) begin : g_pred
            localparam logic [SB-1:0] SIDX = SB'(g);
            assign pred_idx[g] = {SIDX[SB-2:0], dec_i[g]};
            assign ins_bit[g]  = SIDX[SB-1];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_CLEAR: st_d.surv = '0;
            OP_DECIDE: begin
                for (int n = 0; n < NS; n++) begin
                    st_d.surv[n] = {st_q.surv[pred_idx[n]][W-2:0], ins_bit[n]};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign surv_q_o = st_q.surv;

    generate
        for (genvar g = 0; g < NS; g++) begin : g_msb
            assign nxt_msb_o[g] = st_d.surv[g][W-1];
        end
    endgenerate

endmodule

// File: rtl/vit_sp_fill.sv
module vit_sp_fill
    import vit_sp_pkg::*;
#(
    parameter  int SB = 2,
    parameter  int W  = 16,
    localparam int CW = $clog2(W + 1),
    localparam int PW = $clog2(W)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  stage_op_e       op_i,
    input  logic [SB-1:0]   best_i,
    output logic [CW-1:0]   pend_o,
    output logic [SB-1:0]   fb_o,
    output logic            emit_dec_o,
    output logic            emit_drn_o,
    output logic [PW-1:0]   rd_pos_o
);

    typedef struct packed {
        logic [CW-1:0] pend;
        logic [SB-1:0] fb;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        emit_dec_o = 1'b0;
        emit_drn_o = 1'b0;
        unique case (op_i)
            OP_CLEAR: begin
                st_d.pend = '0;
                st_d.fb   = '0;
            end
            OP_DECIDE: begin
                st_d.fb = best_i;
                if (st_q.pend == CW'(W - 1)) begin
                    emit_dec_o = 1'b1;
                end else begin
                    st_d.pend = st_q.pend + CW'(1);
                end
            end
            OP_DRAIN: begin
                if (st_q.pend != '0) begin
                    emit_drn_o = 1'b1;
                    st_d.pend  = st_q.pend - CW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o   = st_q.pend;
    assign fb_o     = st_q.fb;
    assign rd_pos_o = PW'(st_q.pend - CW'(1));

endmodule

// File: rtl/vit_sp_out.sv
module vit_sp_out
    import vit_sp_pkg::*;
#(
    parameter  int SB = 2,
    parameter  int W  = 16,
    localparam int NS = 1 << SB,
    localparam int PW = $clog2(W)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  stage_op_e               op_i,
    input  logic                    emit_dec_i,
    input  logic                    emit_drn_i,
    input  logic [SB-1:0]           best_i,
    input  logic [SB-1:0]           fb_i,
    input  logic [PW-1:0]           rd_pos_i,
    input  logic [NS-1:0][W-1:0]    surv_q_i,
    input  logic [NS-1:0]           nxt_msb_i,
    output logic                    bit_o,
    output logic                    vld_o
);

    typedef struct packed {
        logic dbit;
        logic vld;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (op_i == OP_CLEAR) begin
            st_d.dbit = 1'b0;
        end else if (emit_dec_i) begin
            st_d.dbit = nxt_msb_i[best_i];
            st_d.vld  = 1'b1;
        end else if (emit_drn_i) begin
            st_d.dbit = surv_q_i[fb_i][rd_pos_i];
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.dbit;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem
    import vit_sp_pkg::*;
#(
    parameter  int SB = 2,
    parameter  int W  = 16,
    localparam int NS = 1 << SB,
    localparam int CW = $clog2(W + 1),
    localparam int PW = $clog2(W)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            step_i,
    input  logic            flush_i,
    input  logic [NS-1:0]   dec_i,
    input  logic [SB-1:0]   best_i,
    output logic            bit_o,
    output logic            bit_vld_o
);

    stage_op_e              op;
    logic [NS-1:0][W-1:0]   surv_q;
    logic [NS-1:0]          nxt_msb;
    logic [CW-1:0]          pend;
    logic [SB-1:0]          fb;
    logic                   emit_dec;
    logic                   emit_drn;
    logic [PW-1:0]          rd_pos;

    // Start has priority; a step is a drain when flush is set
    always_comb begin
        op = OP_IDLE;
        if (start_i) begin
            op = OP_CLEAR;
        end else if (step_i) begin
            op = flush_i ? OP_DRAIN : OP_DECIDE;
        end
    end

    vit_sp_bank #(.SB(SB), .W(W)) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op),
        .dec_i     (dec_i),
        .surv_q_o  (surv_q),
        .nxt_msb_o (nxt_msb)
    );

    vit_sp_fill #(.SB(SB), .W(W)) fill_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (op),
        .best_i     (best_i),
        .pend_o     (pend),
        .fb_o       (fb),
        .emit_dec_o (emit_dec),
        .emit_drn_o (emit_drn),
        .rd_pos_o   (rd_pos)
    );

    vit_sp_out #(.SB(SB), .W(W)) out_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (op),
        .emit_dec_i (emit_dec),
        .emit_drn_i (emit_drn),
        .best_i     (best_i),
        .fb_i       (fb),
        .rd_pos_i   (rd_pos),
        .surv_q_i   (surv_q),
        .nxt_msb_i  (nxt_msb),
        .bit_o      (bit_o),
        .vld_o      (bit_vld_o)
    );

endmodule

// File: rtl/vit_sp_chk.sv
module vit_sp_chk #(
    parameter  int SB = 2,
    parameter  int W  = 16,
    localparam int NS = 1 << SB,
    localparam int CW = $clog2(W + 1)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 start_i,
    input logic                 step_i,
    input logic                 flush_i,
    input logic                 bit_o,
    input logic                 bit_vld_o,
    input logic [NS-1:0][W-1:0] surv_i,
    input logic [CW-1:0]        pend_i
);

    logic [CW-1:0] dec_cnt;
    logic          dec_stage;
    logic          drn_stage;

    assign dec_stage = step_i && !flush_i && !start_i;
    assign drn_stage = step_i && flush_i && !start_i;

    // Decide stages seen since reset or start, saturating at the depth
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_cnt <= '0;
        end else if (start_i) begin
            dec_cnt <= '0;
        end else if (dec_stage && dec_cnt != CW'(W)) begin
            dec_cnt <= dec_cnt + CW'(1);
        end
    end

    // R10
    vld_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_vld_o |-> ($past(step_i) && !$past(start_i)));

    // R10
    bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !start_i) |=> $stable(bit_o));

    // R9
    start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (surv_i == '0 && pend_i == '0 && !bit_vld_o && !bit_o));

    // R6
    drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drn_stage |=> $stable(surv_i));

    // R7
    drain_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drn_stage && pend_i == '0) |=> !bit_vld_o);

    // R5
    fill_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_stage && dec_cnt < CW'(W - 1)) |=> !bit_vld_o);

    // R4
    full_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_stage && pend_i == CW'(W - 1)) |=> (bit_vld_o && pend_i == CW'(W - 1)));

endmodule

bind vit_surv_mem vit_sp_chk #(.SB(SB), .W(W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .step_i    (step_i),
    .flush_i   (flush_i),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o),
    .surv_i    (surv_q),
    .pend_i    (pend)
);

// File: tb/vit_surv_mem_tb_top.sv
module vit_surv_mem_tb_top;

    localparam int SB = 2;
    localparam int NS = 4;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          step_i;
    logic          flush_i;
    logic [NS-1:0] dec_i;
    logic [SB-1:0] best_i;
    logic          bit_o;
    logic          bit_vld_o;

    always #5 clk = ~clk;

    vit_surv_mem #(.SB(SB), .W(W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start_i),
        .step_i    (step_i),
        .flush_i   (flush_i),
        .dec_i     (dec_i),
        .best_i    (best_i),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [W-1:0]  m_surv [NS];
    int            m_pend;
    logic [SB-1:0] m_fb;
    logic          m_bit;
    int            n_dec;
    int            n_out;

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int n = 0; n < NS; n++) m_surv[n] = '0;
        m_pend = 0;
        m_fb   = '0;
        m_bit  = 1'b0;
        n_dec  = 0;
        n_out  = 0;
    endtask

    // Called at a falling edge: drive one cycle, predict, check at the next falling edge
    task automatic cycle(bit st, bit sp, bit fl, logic [NS-1:0] d, logic [SB-1:0] b, string req);
        logic          ev;
        logic [W-1:0]  nxt [NS];
        logic [SB-1:0] p;
        ev      = 1'b0;
        start_i = st;
        step_i  = sp;
        flush_i = fl;
        dec_i   = d;
        best_i  = b;
        if (st) begin
            model_clear();
        end else if (sp && !fl) begin
            for (int n = 0; n < NS; n++) begin
                p      = {n[0], d[n]};
                nxt[n] = {m_surv[p][W-2:0], n[1]};
            end
            for (int n = 0; n < NS; n++) m_surv[n] = nxt[n];
            m_fb = b;
            n_dec++;
            if (m_pend == W - 1) begin
                ev    = 1'b1;
                m_bit = m_surv[b][W-1];
            end else begin
                m_pend++;
            end
        end else if (sp && fl) begin
            if (m_pend > 0) begin
                ev    = 1'b1;
                m_bit = m_surv[m_fb][m_pend-1];
                m_pend--;
            end
        end
        if (ev) n_out++;
        @(negedge clk);
        chk(req, bit_vld_o, ev, "valid");
        chk(req, bit_o, m_bit, "bit");
        start_i = 1'b0;
        step_i  = 1'b0;
        flush_i = 1'b0;
    endtask

    initial begin
        start_i = 1'b0;
        step_i  = 1'b0;
        flush_i = 1'b0;
        dec_i   = '0;
        best_i  = '0;
        rst_n   = 1'b0;
        model_clear();
        void'($urandom(32'h5eed_0c3a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", bit_vld_o, 1'b0, "valid after reset");
        chk("R1", bit_o, 1'b0, "bit after reset");

        // R5: fill window stays quiet
        for (int i = 0; i < W - 1; i++) cycle(0, 1, 0, NS'($urandom), SB'($urandom), "R5");
        // R4: first full stage emits
        cycle(0, 1, 0, NS'($urandom), SB'($urandom), "R4");

        // R2 R3: random decide stages
        for (int i = 0; i < 300; i++) cycle(0, 1, 0, NS'($urandom), SB'($urandom), "R2");

        // R10: idle cycles hold the output
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, NS'($urandom), SB'($urandom), "R10");

        // R6 R7: drain the full memory, then drain while empty
        for (int i = 0; i < W - 1; i++) cycle(0, 1, 1, NS'($urandom), SB'($urandom), "R6");
        for (int i = 0; i < 3; i++) cycle(0, 1, 1, NS'($urandom), SB'($urandom), "R7");

        // R9: start overriding a step, then a short stream
        cycle(1, 1, 0, 4'hF, 2'd3, "R9");
        for (int i = 0; i < 5; i++) cycle(0, 1, 0, NS'($urandom), SB'($urandom), "R9");
        for (int i = 0; i < 7; i++) cycle(0, 1, 1, NS'($urandom), SB'($urandom), "R8");
        chk_int("R8", n_out, n_dec, "short stream emitted count");

        // R2: all-ones path through state 3
        cycle(1, 0, 0, '0, '0, "R9");
        for (int i = 0; i < W + 4; i++) cycle(0, 1, 0, 4'hF, 2'd3, "R2");
        chk("R2", bit_o, 1'b1, "all-ones path bit");
        for (int i = 0; i < W; i++) cycle(0, 1, 1, '0, '0, "R8");
        chk_int("R8", n_out, n_dec, "all-ones emitted count");

        // Mixed random with starts and partial drains
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2)       cycle(1, 0, 0, NS'($urandom), SB'($urandom), "R9");
            else if (r < 10) cycle(0, 0, 0, NS'($urandom), SB'($urandom), "R10");
            else if (r < 30) cycle(0, 1, 1, NS'($urandom), SB'($urandom), "R6");
            else             cycle(0, 1, 0, NS'($urandom), SB'($urandom), "R3");
        end
        for (int i = 0; i < W; i++) cycle(0, 1, 1, NS'($urandom), SB'($urandom), "R8");
        chk_int("R8", n_out, n_dec, "random stream emitted count");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule